// File: doc/BRIEF.md
# Multi-Source Prioritized Interrupt Controller

The controller gathers a parameterized set of external interrupt lines and presents one request line per processor target. Each line has its own configuration word: a delivery vector, a 4-bit priority, an active-level choice, an edge-or-level choice and a block bit. A separate routing word chooses the processors that may take the line. A read-only activity flag shows whether the line is still waiting or is being serviced. Software should block a line and wait for this flag to clear before it changes the line's vector or priority.

Each processor has three registers: a task-priority register, an acknowledge register that is read, and an end-of-interrupt register that is written. Reading the acknowledge register returns the vector of the best waiting line for that processor and puts that line into service. A line only qualifies when its priority is strictly above both the task priority and the priority of the innermost interrupt the processor is still serving. Service entries nest as a stack, and an end-of-interrupt write retires the most recent one. When nothing qualifies, the acknowledge read returns a global spurious vector and changes no state.

All register access goes through one 32-bit port. Writes take effect on the clock edge where `wr_en` is sampled. Read data appears on `rdata` after the clock edge where `rd_en` is sampled.

Top module: `ipc_top`

## Requirements
- R1: After reset, every source configuration word reads 0x80000000 (blocked, with all other fields zero), every routing word reads 0, the spurious vector reads 0xFF, every task priority reads 0, and `irq_out` is all zero.
- R2: Register map, using byte addresses: spurious vector at 0x000 (bits 7:0). Source n configuration at 0x100+8n. Source n routing at 0x104+8n. Processor c task priority at 0x200+16c (bits 3:0). Processor c acknowledge at 0x204+16c. Processor c end-of-interrupt at 0x208+16c. The configuration word holds the vector in bits 7:0, the priority in bits 11:8, the sense in bit 16 (1 = level, 0 = edge), the polarity in bit 17 (1 = active high, 0 = active low), the read-only activity flag in bit 30 and the block bit in bit 31. Written fields read back, and a write to bit 30 has no effect.
- R3: A blocked source is never delivered. An edge that arrives while the source is blocked is not latched. Blocking a source discards any edge it has already latched.
- R4: An edge-sensed source latches a request on the inactive-to-active transition of its line, taking polarity into account. The request clears when the source is acknowledged. An edge that arrives while the source is in service is held and is delivered after the end-of-interrupt.
- R5: A level-sensed source requests while its line is at the active level and the source is not in service. If the line is still active after the end-of-interrupt, the source requests again.
- R6: Bit c of a source's routing word allows delivery to processor c. `irq_out[c]` is high, from the clock edge after the state changes, exactly when some source qualifies for processor c.
- R7: Among the sources that qualify, the highest priority wins and a tie goes to the lower source index. A source with priority 0 never qualifies.
- R8: A source qualifies for processor c only when its priority is strictly greater than both the task priority of c and the priority of the newest in-service entry of c.
- R9: An acknowledge read returns the winner's vector in bits 7:0 with the upper bits zero. The winner enters service on that processor, and it is no longer deliverable to any processor until its end-of-interrupt.
- R10: An acknowledge read with no qualifying source returns the spurious vector and changes no state.
- R11: Writing 0 to a processor's end-of-interrupt register ends service of its newest in-service entry. A write of any nonzero value, or a write when no entry is in service, has no effect.
- R12: The activity flag reads 1 exactly when the source is in service, or when it is unblocked and holds a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | External interrupt lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (an acknowledge read has side effects) |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_out | output | NCPU | Per-processor interrupt request |

## Verification
The hardest state to reach is a processor with several nested service entries. In that state a lower-priority request must stay held back by the in-service priority while an edge on an in-service source is latched for later, and each end-of-interrupt then has to expose the right mix of held edges and still-active levels. Directed sequences build this on purpose: a tie, then nesting across three priorities, then an edge during service. A long run of seeded random line toggles, configuration changes, acknowledges and end-of-interrupt writes then piles up service stacks on every processor. A transaction-level model in the bench predicts every acknowledge vector, every request line and every activity flag.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int VEC_W     = 8;
    localparam int PRIO_W    = 4;

    // configuration word layout
    localparam int VEC_LSB   = 0;
    localparam int PRIO_LSB  = 8;
    localparam int LEVEL_BIT = 16;
    localparam int HIGH_BIT  = 17;
    localparam int BUSY_BIT  = 30;
    localparam int BLOCK_BIT = 31;

    // address regions, addr[11:8]
    localparam logic [3:0] RGN_GLOBAL = 4'h0;
    localparam logic [3:0] RGN_SRC    = 4'h1;
    localparam logic [3:0] RGN_CPU    = 4'h2;

    // processor register offsets, addr[3:2]
    localparam logic [1:0] CPU_TASK = 2'd0;
    localparam logic [1:0] CPU_ACK  = 2'd1;
    localparam logic [1:0] CPU_EOI  = 2'd2;

    localparam logic [VEC_W-1:0] SPUR_RST = 8'hFF;

    typedef struct packed {
        logic              block;
        logic              high;
        logic              level;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;
endpackage

// File: rtl/ipc_source.sv
module ipc_source
    import ipc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_i,
    input  logic            cfg_we_i,
    input  src_cfg_t        cfg_wdata_i,
    input  logic            dest_we_i,
    input  logic [NCPU-1:0] dest_wdata_i,
    input  logic            take_i,
    input  logic            free_i,
    output src_cfg_t        cfg_o,
    output logic [NCPU-1:0] dest_o,
    output logic            ready_o,
    output logic            busy_o
);
    typedef struct packed {
        src_cfg_t        cfg;
        logic [NCPU-1:0] dest;
        logic            act;
        logic            edge_pend;
        logic            svc;
    } state_t;

    state_t q, d;
    logic   act_now;
    logic   pending;

    always_comb begin
        d       = q;
        act_now = q.cfg.high ? line_i : ~line_i;
        d.act   = act_now;
        if (cfg_we_i) begin
            d.cfg = cfg_wdata_i;
        end
        if (dest_we_i) begin
            d.dest = dest_wdata_i;
        end
        if (take_i) begin
            d.svc       = 1'b1;
            d.edge_pend = 1'b0;
        end
        if (free_i) begin
            d.svc = 1'b0;
        end
        if (!q.cfg.level && act_now && !q.act && !d.cfg.block) begin
            d.edge_pend = 1'b1;
        end
        if (d.cfg.block) begin
            d.edge_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.cfg.block <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pending = q.cfg.level ? q.act : q.edge_pend;
    assign ready_o = pending & ~q.cfg.block & ~q.svc;
    assign busy_o  = ready_o | q.svc;
    assign cfg_o   = q.cfg;
    assign dest_o  = q.dest;

    AST_BLOCK_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg.block && !cfg_we_i) |=> !q.edge_pend); // R3
    AST_TAKE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> ready_o); // R9
    AST_TAKE_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (q.svc && busy_o)); // R9
    AST_FREE_ONLY_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |-> q.svc); // R11
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]              ready_i,
    input  logic [NSRC-1:0]              route_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    input  logic [NSRC-1:0][VEC_W-1:0]   vec_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic [PRIO_W-1:0]            prio_o,
    output logic [VEC_W-1:0]             vec_o
);
    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        vec_o  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ready_i[i] && route_i[i] && (prio_i[i] > thr_i) && (prio_i[i] >= prio_o)) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i];
                vec_o  = vec_i[i];
            end
        end
    end
endmodule

// File: rtl/ipc_cpu.sv
module ipc_cpu
    import ipc_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_we_i,
    input  logic [PRIO_W-1:0] task_wdata_i,
    input  logic              push_i,
    input  logic [IDX_W-1:0]  push_idx_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic [PRIO_W-1:0] task_o,
    output logic              top_valid_o,
    output logic [IDX_W-1:0]  top_idx_o,
    output logic [PRIO_W-1:0] thr_o
);
    // each nested entry is strictly above the previous, so one slot per nonzero level
    localparam int DEPTH = (2 ** PRIO_W) - 1;
    localparam int SP_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } entry_t;

    typedef struct packed {
        logic [PRIO_W-1:0]       task_prio;
        logic [SP_W-1:0]         sp;
        entry_t [DEPTH-1:0]      stack;
    } state_t;

    state_t            q, d;
    entry_t            top_e;
    logic [PRIO_W-1:0] cur_prio;

    always_comb begin
        d = q;
        if (task_we_i) begin
            d.task_prio = task_wdata_i;
        end
        if (push_i && (q.sp != SP_W'(DEPTH))) begin
            d.stack[q.sp] = '{idx: push_idx_i, prio: push_prio_i};
            d.sp          = q.sp + 1'b1;
        end else if (pop_i && (q.sp != '0)) begin
            d.sp = q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign top_valid_o = (q.sp != '0);
    assign top_e       = top_valid_o ? q.stack[q.sp - 1'b1] : '0;
    assign top_idx_o   = top_e.idx;
    assign cur_prio    = top_valid_o ? top_e.prio : '0;
    assign thr_o       = (cur_prio > q.task_prio) ? cur_prio : q.task_prio;
    assign task_o      = q.task_prio;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.sp != SP_W'(DEPTH))); // R8
    AST_NEST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> ((push_prio_i > cur_prio) && (push_prio_i > q.task_prio))); // R8
endmodule

// File: rtl/ipc_top.sv
module ipc_top
    import ipc_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCPU-1:0]   irq_out
);
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic [VEC_W-1:0]  spur;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t q, d;

    // address decode
    logic       word_ok, glob_hit, src_hit, cpu_hit, spur_sel;
    logic [3:0] src_slot;
    logic [1:0] cpu_slot, cpu_ofs;
    logic       src_in_range, cpu_in_range;

    assign word_ok      = (addr[1:0] == 2'b00);
    assign glob_hit     = word_ok && (addr[11:8] == RGN_GLOBAL);
    assign spur_sel     = glob_hit && (addr[7:2] == '0);
    assign src_slot     = addr[6:3];
    assign src_in_range = (int'(src_slot) < NSRC);
    assign src_hit      = word_ok && (addr[11:8] == RGN_SRC) && !addr[7] && src_in_range;
    assign cpu_slot     = addr[5:4];
    assign cpu_ofs      = addr[3:2];
    assign cpu_in_range = (int'(cpu_slot) < NCPU);
    assign cpu_hit      = word_ok && (addr[11:8] == RGN_CPU) && (addr[7:6] == 2'b00) && cpu_in_range;

    src_cfg_t  wcfg;
    assign wcfg = '{block: wdata[BLOCK_BIT], high: wdata[HIGH_BIT], level: wdata[LEVEL_BIT],
                    prio: wdata[PRIO_LSB +: PRIO_W], vec: wdata[VEC_LSB +: VEC_W]};

    src_cfg_t                    cfg   [NSRC];
    logic [NCPU-1:0]             dest  [NSRC];
    logic [NSRC-1:0]             ready, busy, take, free_s;
    logic [NSRC-1:0][PRIO_W-1:0] prio_all;
    logic [NSRC-1:0][VEC_W-1:0]  vec_all;

    logic [NCPU-1:0][NSRC-1:0]   route;
    logic [NCPU-1:0]             hit, ack_rd, push, pop, top_valid;
    logic [NCPU-1:0][IDX_W-1:0]  win_idx, top_idx;
    logic [NCPU-1:0][PRIO_W-1:0] win_prio, thr, task_p;
    logic [NCPU-1:0][VEC_W-1:0]  win_vec;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic cfg_we, dest_we;
        assign cfg_we  = wr_en && src_hit && (int'(src_slot) == s) && !addr[2];
        assign dest_we = wr_en && src_hit && (int'(src_slot) == s) &&  addr[2];

        ipc_source #(.NCPU(NCPU)) u_src (
            .clk          (clk),
            .rst_n        (rst_n),
            .line_i       (irq_in[s]),
            .cfg_we_i     (cfg_we),
            .cfg_wdata_i  (wcfg),
            .dest_we_i    (dest_we),
            .dest_wdata_i (wdata[NCPU-1:0]),
            .take_i       (take[s]),
            .free_i       (free_s[s]),
            .cfg_o        (cfg[s]),
            .dest_o       (dest[s]),
            .ready_o      (ready[s]),
            .busy_o       (busy[s])
        );
        assign prio_all[s] = cfg[s].prio;
        assign vec_all[s]  = cfg[s].vec;
        for (genvar c = 0; c < NCPU; c++) begin : g_route
            assign route[c][s] = dest[s][c];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic sel, task_we;
        assign sel       = cpu_hit && (int'(cpu_slot) == c);
        assign task_we   = wr_en && sel && (cpu_ofs == CPU_TASK);
        assign ack_rd[c] = rd_en && sel && (cpu_ofs == CPU_ACK);
        assign push[c]   = ack_rd[c] && hit[c];
        assign pop[c]    = wr_en && sel && (cpu_ofs == CPU_EOI) && (wdata == '0);

        ipc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
            .ready_i (ready),
            .route_i (route[c]),
            .prio_i  (prio_all),
            .vec_i   (vec_all),
            .thr_i   (thr[c]),
            .hit_o   (hit[c]),
            .idx_o   (win_idx[c]),
            .prio_o  (win_prio[c]),
            .vec_o   (win_vec[c])
        );

        ipc_cpu #(.NSRC(NSRC), .IDX_W(IDX_W)) u_cpu (
            .clk          (clk),
            .rst_n        (rst_n),
            .task_we_i    (task_we),
            .task_wdata_i (wdata[PRIO_W-1:0]),
            .push_i       (push[c]),
            .push_idx_i   (win_idx[c]),
            .push_prio_i  (win_prio[c]),
            .pop_i        (pop[c]),
            .task_o       (task_p[c]),
            .top_valid_o  (top_valid[c]),
            .top_idx_o    (top_idx[c]),
            .thr_o        (thr[c])
        );

        AST_WINNER_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |-> (ready[win_idx[c]] && dest[win_idx[c]][c])); // R6
        AST_SPURIOUS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[c] && !hit[c]) |=> (rdata == {{(DATA_W-VEC_W){1'b0}}, $past(q.spur)})); // R10
    end

    // one bus access per cycle, so at most one source enters or leaves service
    always_comb begin
        take   = '0;
        free_s = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (push[c]) begin
                take[win_idx[c]] = 1'b1;
            end
            if (pop[c] && top_valid[c]) begin
                free_s[top_idx[c]] = 1'b1;
            end
        end
    end

    always_comb begin
        d = q;
        if (wr_en && spur_sel) begin
            d.spur = wdata[VEC_W-1:0];
        end
        if (rd_en) begin
            d.rdata = '0;
            if (spur_sel) begin
                d.rdata[VEC_W-1:0] = q.spur;
            end else if (src_hit) begin
                if (addr[2]) begin
                    d.rdata[NCPU-1:0] = dest[src_slot];
                end else begin
                    d.rdata[VEC_LSB +: VEC_W]   = cfg[src_slot].vec;
                    d.rdata[PRIO_LSB +: PRIO_W] = cfg[src_slot].prio;
                    d.rdata[LEVEL_BIT]          = cfg[src_slot].level;
                    d.rdata[HIGH_BIT]           = cfg[src_slot].high;
                    d.rdata[BUSY_BIT]           = busy[src_slot];
                    d.rdata[BLOCK_BIT]          = cfg[src_slot].block;
                end
            end else if (cpu_hit) begin
                case (cpu_ofs)
                    CPU_TASK: d.rdata[PRIO_W-1:0] = task_p[cpu_slot];
                    CPU_ACK:  d.rdata[VEC_W-1:0]  = hit[cpu_slot] ? win_vec[cpu_slot] : q.spur;
                    default:  d.rdata             = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.spur <= SPUR_RST;
        end else begin
            q <= d;
        end
    end

    assign rdata   = q.rdata;
    assign irq_out = hit;

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)); // R9
endmodule

// File: tb/ipc_top_test.sv
module ipc_top_test;
    localparam int NSRC = 16;
    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_in = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCPU-1:0]   irq_out;

    always #5 clk = ~clk;

    ipc_top #(.NSRC(NSRC), .NCPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // transaction-level model
    bit m_block [NSRC];
    bit m_lvl   [NSRC];
    bit m_high  [NSRC];
    bit m_act   [NSRC];
    bit m_ep    [NSRC];
    bit m_svc   [NSRC];
    int m_prio  [NSRC];
    int m_vec   [NSRC];
    int m_dest  [NSRC];
    int m_task  [NCPU];
    int m_sp    [NCPU];
    int m_sidx  [NCPU][16];
    int m_spr   [NCPU][16];
    int m_spur;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    function automatic bit m_ready(int s);
        bit p;
        p = m_lvl[s] ? m_act[s] : m_ep[s];
        return p && !m_block[s] && !m_svc[s];
    endfunction

    function automatic int m_thr(int c);
        int cur;
        cur = (m_sp[c] > 0) ? m_spr[c][m_sp[c]-1] : 0;
        return (cur > m_task[c]) ? cur : m_task[c];
    endfunction

    function automatic int m_pick(int c);
        int best = -1;
        int bp = 0;
        int t = m_thr(c);
        for (int s = 0; s < NSRC; s++) begin
            if (m_ready(s) && m_dest[s][c] && m_prio[s] > t && m_prio[s] > bp) begin
                best = s;
                bp = m_prio[s];
            end
        end
        return best;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_irq(input string tag);
        for (int c = 0; c < NCPU; c++) begin
            check(tag, {31'b0, irq_out[c]}, {31'b0, (m_pick(c) >= 0)});
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic set_cfg(input int s, input bit blk, input bit lvl, input bit high,
                           input int prio, input int vec);
        logic [31:0] w;
        bit a;
        // bit 30 is written as 1 on purpose: it must be ignored (R2)
        w = {blk, 1'b1, 12'b0, high, lvl, 4'b0, prio[3:0], vec[7:0]};
        bus_write(12'h100 + 12'(8*s), w);
        m_block[s] = blk; m_lvl[s] = lvl; m_high[s] = high;
        m_prio[s] = prio; m_vec[s] = vec;
        a = high ? irq_in[s] : ~irq_in[s];
        if (!lvl && a && !m_act[s] && !blk) m_ep[s] = 1'b1;
        m_act[s] = a;
        if (blk) m_ep[s] = 1'b0;
    endtask

    task automatic set_dest(input int s, input int msk);
        bus_write(12'h104 + 12'(8*s), 32'(msk));
        m_dest[s] = msk;
    endtask

    task automatic set_task(input int c, input int p);
        bus_write(12'h200 + 12'(16*c), 32'(p));
        m_task[c] = p;
    endtask

    task automatic set_lines(input logic [NSRC-1:0] v);
        bit a;
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        for (int s = 0; s < NSRC; s++) begin
            a = m_high[s] ? v[s] : ~v[s];
            if (!m_lvl[s] && a && !m_act[s] && !m_block[s]) m_ep[s] = 1'b1;
            m_act[s] = a;
        end
    endtask

    task automatic ack(input int c, input string tag);
        logic [31:0] got;
        int p;
        int e;
        p = m_pick(c);
        bus_read(12'h204 + 12'(16*c), got);
        if (p < 0) begin
            e = m_spur;
        end else begin
            e = m_vec[p];
            m_sidx[c][m_sp[c]] = p;
            m_spr[c][m_sp[c]] = m_prio[p];
            m_sp[c]++;
            m_svc[p] = 1'b1;
            m_ep[p] = 1'b0;
        end
        check(tag, got, 32'(e));
    endtask

    task automatic eoi(input int c, input logic [31:0] v);
        bus_write(12'h208 + 12'(16*c), v);
        if (v == 0 && m_sp[c] > 0) begin
            m_sp[c]--;
            m_svc[m_sidx[c][m_sp[c]]] = 1'b0;
        end
    endtask

    task automatic read_cfg(input int s, input string tag);
        logic [31:0] got;
        logic [31:0] e;
        bus_read(12'h100 + 12'(8*s), got);
        e = {m_block[s], (m_ready(s) || m_svc[s]), 12'b0, m_high[s], m_lvl[s], 4'b0,
             4'(m_prio[s]), 8'(m_vec[s])};
        check(tag, got, e);
    endtask

    initial begin
        logic [31:0] v;
        for (int s = 0; s < NSRC; s++) begin
            m_block[s] = 1'b1; m_lvl[s] = 1'b0; m_high[s] = 1'b0; m_act[s] = 1'b1;
            m_ep[s] = 1'b0; m_svc[s] = 1'b0; m_prio[s] = 0; m_vec[s] = 0; m_dest[s] = 0;
        end
        for (int c = 0; c < NCPU; c++) begin
            m_task[c] = 0; m_sp[c] = 0;
        end
        m_spur = 8'hFF;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_irq("R1");
        read_cfg(0, "R1");
        read_cfg(NSRC-1, "R1");
        bus_read(12'h104, v);       check("R1", v, 32'h0);
        bus_read(12'h000, v);       check("R1", v, 32'hFF);
        bus_read(12'h230, v);       check("R1", v, 32'h0);
        ack(1, "R10");

        // R2 field readback, activity bit not writable
        set_cfg(3, 1'b0, 1'b1, 1'b1, 5, 8'h33);
        read_cfg(3, "R2");
        set_cfg(3, 1'b1, 1'b0, 1'b0, 0, 8'h00);
        read_cfg(3, "R2");
        bus_write(12'h000, 32'h0000_00E7);
        m_spur = 8'hE7;
        bus_read(12'h000, v);       check("R2", v, 32'hE7);

        // R7 tie: edge src 2 and level src 5, both priority 6, routed to cpu0
        set_lines('0);
        set_cfg(2, 1'b0, 1'b0, 1'b1, 6, 8'h22);
        set_cfg(5, 1'b0, 1'b1, 1'b1, 6, 8'h55);
        set_dest(2, 1);
        set_dest(5, 1);
        set_lines(16'h0024);
        check_irq("R6");
        read_cfg(2, "R12");
        ack(0, "R7");
        read_cfg(2, "R12");
        check_irq("R8");                 // src 5 priority 6 not above in-service 6
        ack(0, "R10");
        // R4 edge during service is held
        set_lines(16'h0020);
        set_lines(16'h0024);
        eoi(0, 32'h5);                   // R11 nonzero ignored
        ack(0, "R11");
        eoi(0, 32'h0);
        ack(0, "R4");                    // held edge of src 2 wins the tie again
        eoi(0, 32'h0);
        ack(0, "R5");                    // level src 5 still active
        eoi(0, 32'h0);
        ack(0, "R5");                    // re-pends after end of service
        eoi(0, 32'h0);
        eoi(0, 32'h0);                   // R11 empty stack
        // R8 task priority
        set_task(0, 6);
        check_irq("R8");
        ack(0, "R8");
        set_task(0, 0);
        // R3 blocking discards a latched edge
        set_lines(16'h0020);
        set_lines(16'h0024);
        read_cfg(2, "R12");
        set_cfg(2, 1'b1, 1'b0, 1'b1, 6, 8'h22);
        read_cfg(2, "R3");
        set_cfg(2, 1'b0, 1'b0, 1'b1, 6, 8'h22);
        read_cfg(2, "R3");
        ack(0, "R3");
        eoi(0, 32'h0);
        set_cfg(5, 1'b1, 1'b1, 1'b1, 6, 8'h55);
        // R6 routing
        set_cfg(7, 1'b0, 1'b1, 1'b0, 4, 8'h77);    // level, active low, line is low
        set_dest(7, 4);
        check_irq("R6");
        ack(1, "R6");
        ack(2, "R6");
        eoi(2, 32'h0);
        set_cfg(7, 1'b1, 1'b1, 1'b0, 4, 8'h77);
        // R7 priority 0 never
        set_cfg(8, 1'b0, 1'b1, 1'b0, 0, 8'h88);
        set_dest(8, 15);
        check_irq("R7");
        ack(3, "R7");
        // R8 nesting on cpu3
        set_dest(10, 8); set_dest(11, 8); set_dest(12, 8);
        set_cfg(10, 1'b0, 1'b1, 1'b0, 3, 8'hA0);
        ack(3, "R9");
        set_cfg(12, 1'b0, 1'b1, 1'b0, 9, 8'hC0);
        ack(3, "R8");
        set_cfg(11, 1'b0, 1'b1, 1'b0, 5, 8'hB0);
        check_irq("R8");
        ack(3, "R8");
        eoi(3, 32'h0);
        ack(3, "R8");
        eoi(3, 32'h0);
        eoi(3, 32'h0);
        ack(3, "R5");

        // seeded random mix
        for (int k = 0; k < 700; k++) begin
            int op;
            int s;
            int c;
            op = $urandom % 10;
            s  = $urandom % NSRC;
            c  = $urandom % NCPU;
            case (op)
                0, 1, 2: set_lines(irq_in ^ NSRC'(1 << s) ^ NSRC'(($urandom % 4 == 0) ? (1 << ($urandom % NSRC)) : 0));
                3: set_cfg(s, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 16, $urandom % 256);
                4: set_dest(s, $urandom % 16);
                5: set_task(c, ($urandom % 3 == 0) ? $urandom % 8 : 0);
                6, 7: ack(c, "R9");
                8: eoi(c, ($urandom % 7 == 0) ? 32'($urandom % 5 + 1) : 32'h0);
                default: read_cfg(s, "R12");
            endcase
            check_irq("R6");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule